// File: doc/BRIEF.md
# Dual Gated-Edge Binary Counter

This block holds two independent up counters, each four bits wide by default. Every counter has two count pins of opposite polarity. One pin counts on its rising transition while the other pin is high. The other pin counts on its falling transition while the first pin is low. Either pin can therefore serve as the count source, with its partner acting as a level enable. Both pins are brought into the system clock domain by synchronizer flops, and their transitions are found by comparing the synchronized level with the level one cycle earlier.

Each counter has its own active-high clear. The clear empties the counter at once, without waiting for a clock edge. Its release passes through a short synchronizer, so the counter only resumes counting a few cycles later. Each lane also flags terminal count (all ones). When a counter wraps, its top bit falls, so that bit can feed the falling-edge pin of a following lane whose rising-edge pin is held low. This lets the two lanes, or further instances, be chained into wider counters or frequency dividers.

Top module: `twin_gated_counter`

## Requirements
- R1: While the system reset `rst_n` is low, and just after it is released, every count reads 0 and every terminal-count flag reads 0.
- R2: A low-to-high transition on `rise_src_i[l]` while `fall_src_i[l]` is high adds one to lane l.
- R3: A high-to-low transition on `fall_src_i[l]` while `rise_src_i[l]` is low adds one to lane l.
- R4: A rising `rise_src_i[l]` while `fall_src_i[l]` is low, and a falling `fall_src_i[l]` while `rise_src_i[l]` is high, leave lane l unchanged.
- R5: A falling `rise_src_i[l]` or a rising `fall_src_i[l]` never changes lane l.
- R6: While `clear_i[l]` is high, lane l reads 0, starting in the same clock phase the clear rises, and count transitions have no effect.
- R7: After `clear_i[l]` falls, the first two rising clock edges never change lane l. A qualifying transition presented in the same low clock phase as the release is counted on the third edge.
- R8: The lanes are independent. Counting or clearing one lane never alters the other.
- R9: A count steps by exactly one and wraps from 15 to 0. `tc_o[l]` is 1 exactly when lane l reads 15.
- R10: A qualifying transition presented between two rising clock edges shows on `count_o` after the third rising edge that follows it, and not before.
- R11: Feeding bit 3 of lane 0 into `fall_src_i[1]`, with `rise_src_i[1]` held low, makes lane 1 advance once per 16 counts of lane 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| rise_src_i | input | NUM_LANES | Per-lane count pin active on its rising transition, bit l for lane l |
| fall_src_i | input | NUM_LANES | Per-lane count pin active on its falling transition, bit l for lane l |
| clear_i | input | NUM_LANES | Per-lane active-high clear, bit l for lane l |
| count_o | output | NUM_LANES*CNT_W | Counts, lane l at bits [l*CNT_W +: CNT_W] |
| tc_o | output | NUM_LANES | Per-lane terminal-count flag |

## Verification
A transition on a count pin needs two synchronizer flops and one history flop before it reaches the counter. It therefore shows on `count_o` after the third rising edge following the change. A clear empties its lane within the same phase, and counting resumes no earlier than the third edge after the release. The bench drives every pin on falling clock edges and compares against a reference model once per cycle at the falling edge. The model keeps a history of the levels sampled at each rising edge and applies a transition two to three samples late, matching the latency above. The latency check and the release checks sample exactly on the edge before the expected change and on the edge after it.

// File: rtl/tgc_pkg.sv
package tgc_pkg;

  // Synchronized levels of one lane's two count pins.
  typedef struct packed {
    logic src_a;   // counts on its rising transition
    logic src_b;   // counts on its falling transition
  } pin_pair_t;

endpackage

// File: rtl/tgc_sync.sv
module tgc_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '{default: '0};
    end else begin
      chain_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) begin
        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/tgc_edge_qual.sv
module tgc_edge_qual
  import tgc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pin_pair_t lvl_i,
  output logic      step_o
);

  pin_pair_t prev_q;
  logic      rise_a_hit;
  logic      fall_b_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= lvl_i;
    end
  end

  // Each pin is gated by the current level of its partner.
  always_comb begin
    rise_a_hit = lvl_i.src_a & ~prev_q.src_a &  lvl_i.src_b;
    fall_b_hit = ~lvl_i.src_b & prev_q.src_b & ~lvl_i.src_a;
    step_o     = rise_a_hit | fall_b_hit;
  end

endmodule

// File: rtl/tgc_lane.sv
module tgc_lane #(
  parameter int unsigned CNT_W      = 4,
  parameter int unsigned REL_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] count_o,
  output logic             tc_o
);

  logic                  lane_arst_n;
  logic [REL_STAGES-1:0] rel_q;
  logic                  run;
  logic                  count_en;
  logic [CNT_W-1:0]      count_d;
  logic [CNT_W-1:0]      count_q;

  // The clear acts asynchronously; its release is resynchronized.
  assign lane_arst_n = rst_n & ~clear_i;

  always_ff @(posedge clk or negedge lane_arst_n) begin
    if (!lane_arst_n) begin
      rel_q <= '0;
    end else begin
      rel_q <= {rel_q[REL_STAGES-2:0], 1'b1};
    end
  end

  assign run = rel_q[REL_STAGES-1];

  always_comb begin
    count_en = run & step_i;
    count_d  = count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge lane_arst_n) begin
    if (!lane_arst_n) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  assign count_o = count_q;
  assign tc_o    = &count_q;

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |-> (count_q == '0)); // R6

  AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clear_i) |=> (count_q == '0) ##1 (count_q == '0)); // R7

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q != $past(count_q)) |-> ((count_q == $past(count_q) + 1'b1) || (count_q == '0))); // R9

  AST_NO_STRAY_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ((count_q != $past(count_q)) && (count_q != '0)) |-> $past(step_i)); // R4

endmodule

// File: rtl/twin_gated_counter.sv
module twin_gated_counter
  import tgc_pkg::*;
#(
  parameter int unsigned NUM_LANES   = 2,
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_LANES-1:0]       rise_src_i,
  input  logic [NUM_LANES-1:0]       fall_src_i,
  input  logic [NUM_LANES-1:0]       clear_i,
  output logic [NUM_LANES*CNT_W-1:0] count_o,
  output logic [NUM_LANES-1:0]       tc_o
);

  localparam int unsigned PIN_W = 2 * NUM_LANES;

  logic [PIN_W-1:0] pins_sync;

  tgc_sync #(
    .WIDTH  (PIN_W),
    .STAGES (SYNC_STAGES)
  ) u_pin_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({fall_src_i, rise_src_i}),
    .sync_o  (pins_sync)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    pin_pair_t lane_lvl;
    logic      lane_step;

    assign lane_lvl.src_a = pins_sync[l];
    assign lane_lvl.src_b = pins_sync[NUM_LANES + l];

    tgc_edge_qual u_qual (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (lane_lvl),
      .step_o (lane_step)
    );

    tgc_lane #(
      .CNT_W      (CNT_W),
      .REL_STAGES (2)
    ) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (clear_i[l]),
      .step_i  (lane_step),
      .count_o (count_o[l*CNT_W +: CNT_W]),
      .tc_o    (tc_o[l])
    );
  end

endmodule

// File: tb/test_twin_gated_counter.sv
module test_twin_gated_counter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rise_src = '0;
  logic [1:0] fall_src = '0;
  logic [1:0] clear = '0;
  logic [7:0] count;
  logic [1:0] tc;

  int    checks = 0;
  int    errors = 0;
  bit    compare_on = 0;
  bit    cascade = 0;
  bit    done = 0;
  string phase = "R1";

  // reference model: per-lane history of sampled levels, index 0 = newest
  int ha [2][4];
  int hb [2][4];
  int hm [2][4];
  int mc [2];

  twin_gated_counter i_twin_gated_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_src_i (rise_src),
    .fall_src_i (fall_src),
    .clear_i    (clear),
    .count_o    (count),
    .tc_o       (tc)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    for (int l = 0; l < 2; l++) begin
      for (int k = 3; k > 0; k--) begin
        ha[l][k] = ha[l][k-1];
        hb[l][k] = hb[l][k-1];
        hm[l][k] = hm[l][k-1];
      end
      if (!rst_n) begin
        ha[l][0] = 0; hb[l][0] = 0; hm[l][0] = 1;
      end else begin
        ha[l][0] = rise_src[l]; hb[l][0] = fall_src[l]; hm[l][0] = clear[l];
      end
      if (hm[l][0] != 0) begin
        mc[l] = 0;
      end else if (hm[l][1] == 0 && hm[l][2] == 0 &&
                   ((ha[l][2] == 1 && ha[l][3] == 0 && hb[l][2] == 1) ||
                    (hb[l][2] == 0 && hb[l][3] == 1 && ha[l][2] == 0))) begin
        mc[l] = (mc[l] + 1) % 16;
      end
    end
  end

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: %s got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (compare_on) begin
      for (int l = 0; l < 2; l++) begin
        chk(phase, $sformatf("model compare lane %0d count", l), int'(count[l*4 +: 4]), mc[l]);
        chk("R9", $sformatf("model compare lane %0d tc", l), int'(tc[l]), (mc[l] == 15) ? 1 : 0);
      end
    end
    if (cascade) fall_src[1] = count[3];
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pulse_a(int l, int n);
    for (int i = 0; i < n; i++) begin
      rise_src[l] = 1'b1; ticks(4);
      rise_src[l] = 1'b0; ticks(4);
    end
  endtask

  function automatic int lane_cnt(int l);
    return int'(count[l*4 +: 4]);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    ticks(5);
    chk("R1", "lane 0 count in reset", lane_cnt(0), 0);
    chk("R1", "lane 1 count in reset", lane_cnt(1), 0);
    rst_n = 1'b1;
    compare_on = 1;
    ticks(4);
    chk("R1", "lane 0 count after reset", lane_cnt(0), 0);
    chk("R1", "tc after reset", int'(tc), 0);

    // R5: rising fall_src alone does not count
    phase = "R5";
    fall_src[0] = 1'b1; ticks(5);
    chk("R5", "lane 0 after rising fall_src", lane_cnt(0), 0);

    // R2: rising edges on rise_src with fall_src high
    phase = "R2";
    pulse_a(0, 3);
    chk("R2", "lane 0 after 3 rise pulses", lane_cnt(0), 3);

    // R10: latency of three rising edges
    phase = "R10";
    rise_src[0] = 1'b1; ticks(2);
    chk("R10", "lane 0 two edges after transition", lane_cnt(0), 3);
    ticks(1);
    chk("R10", "lane 0 three edges after transition", lane_cnt(0), 4);
    rise_src[0] = 1'b0; ticks(5);
    chk("R5", "lane 0 after falling rise_src", lane_cnt(0), 4);

    // R3: falling edges on fall_src with rise_src low
    phase = "R3";
    fall_src[0] = 1'b0; ticks(4);
    fall_src[0] = 1'b1; ticks(4);
    fall_src[0] = 1'b0; ticks(4);
    fall_src[0] = 1'b1; ticks(4);
    chk("R3", "lane 0 after 2 falling fall_src", lane_cnt(0), 6);

    // R4: wrongly gated transitions
    phase = "R4";
    rise_src[0] = 1'b1; ticks(5);
    chk("R2", "lane 0 gated rise", lane_cnt(0), 7);
    fall_src[0] = 1'b0; ticks(5);
    chk("R4", "lane 0 fall_src falls while rise_src high", lane_cnt(0), 7);
    rise_src[0] = 1'b0; ticks(5);
    rise_src[0] = 1'b1; ticks(5);
    chk("R4", "lane 0 rise_src rises while fall_src low", lane_cnt(0), 7);
    rise_src[0] = 1'b0; ticks(5);
    chk("R8", "lane 1 untouched", lane_cnt(1), 0);

    // R9: wrap and terminal count
    phase = "R9";
    fall_src[0] = 1'b1; ticks(5);
    chk("R5", "lane 0 after rising fall_src", lane_cnt(0), 7);
    pulse_a(0, 8);
    chk("R9", "lane 0 at top", lane_cnt(0), 15);
    chk("R9", "lane 0 tc at top", int'(tc[0]), 1);
    pulse_a(0, 1);
    chk("R9", "lane 0 wrapped", lane_cnt(0), 0);
    chk("R9", "lane 0 tc after wrap", int'(tc[0]), 0);

    // R6 / R8: clear
    phase = "R6";
    fall_src[1] = 1'b1; ticks(4);
    pulse_a(1, 5);
    chk("R2", "lane 1 after 5 pulses", lane_cnt(1), 5);
    pulse_a(0, 3);
    clear[1] = 1'b1;
    #2;
    chk("R6", "lane 1 cleared in same phase", lane_cnt(1), 0);
    chk("R8", "lane 0 unaffected by lane 1 clear", lane_cnt(0), 3);
    pulse_a(1, 2);
    chk("R6", "lane 1 held while clear high", lane_cnt(1), 0);

    // R7: release window
    phase = "R7";
    rise_src[1] = 1'b1; tick();
    clear[1] = 1'b0; ticks(6);
    chk("R7", "edge at second edge after release ignored", lane_cnt(1), 0);
    rise_src[1] = 1'b0; ticks(4);
    pulse_a(1, 1);
    chk("R7", "counting resumes", lane_cnt(1), 1);
    clear[1] = 1'b1; ticks(2);
    clear[1] = 1'b0; rise_src[1] = 1'b1; ticks(5);
    chk("R7", "edge at third edge after release counted", lane_cnt(1), 1);
    rise_src[1] = 1'b0; ticks(4);

    // R11: cascade lane 0 bit 3 into lane 1 falling pin
    phase = "R11";
    fall_src[1] = 1'b0; ticks(4);
    clear = 2'b11; ticks(2);
    clear = 2'b00; ticks(4);
    cascade = 1;
    pulse_a(0, 16);
    ticks(6);
    chk("R11", "lane 1 after 16 lane 0 counts", lane_cnt(1), 1);
    pulse_a(0, 16);
    ticks(6);
    chk("R11", "lane 1 after 32 lane 0 counts", lane_cnt(1), 2);
    chk("R11", "lane 0 after 32 counts", lane_cnt(0), 0);
    cascade = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule